// File: doc/BRIEF.md
# Accumulator Move Shifter and Limiter

This block sits between two 56-bit accumulators and a 48-bit data move bus. Each accumulator is laid out, from the top bit down, as an 8-bit extension byte, a 24-bit middle word and a 24-bit low word. A read select picks what goes onto the bus. A whole accumulator read as one 24-bit or one 48-bit word is first scaled: no shift, one place left, or one place arithmetic right. It is then saturated to the width of the destination. Raw reads of a single part, and the 48-bit middle-plus-low form, are passed through unchanged.

On the write side, a write select and the bus word produce new accumulator values and per-accumulator write enables. A full-accumulator write sign-extends the incoming word into the extension byte and clears whatever lies below it. A part write replaces only the selected part and keeps the rest of the current accumulator contents. Paired forms join the middle words of both accumulators, in either order, into one 48-bit word for both reads and writes. A sticky flag records any read that had to be saturated.

Top module: `acc_move_shift_limit`

## Requirements
- R1: Select codes, used for both rd_sel_i and wr_sel_i: 0 word A, 1 word B, 2 pair A-mid:B-mid, 3 pair B-mid:A-mid, 4 A mid:low, 5 B mid:low, 6 A extension, 7 A middle, 8 A low, 9 B extension, 10 B middle, 11 B low, 12 long A, 13 long B. Codes 14 and 15 read as zero and write nothing. A 24-bit bus value occupies bits 23:0, and bits 47:24 read as zero.
- R2: A word read (codes 0 and 1) returns the scaled middle word. When extension byte and bit 47 of the scaled value are not all equal, lim_o is high and the result is 0x7FFFFF for a positive sign or 0x800000 for a negative sign.
- R3: A long read (codes 12 and 13) returns scaled middle:low as 48 bits. It saturates to 0x7FFFFFFFFFFF or 0x800000000000 under the same overflow rule.
- R4: scale_i selects 0 no shift, 1 left by one, 2 arithmetic right by one, 3 no shift. The overflow check uses the shifted value, with the sign taken from the top bit after the shift.
- R5: Paired reads place the first-named accumulator's middle word in bits 47:24. Each half is scaled and limited on its own, and lim_o is high if either half saturated.
- R6: Raw part reads (codes 4 to 11) never scale or limit, and lim_o stays low. An extension read returns the byte sign-extended to 24 bits.
- R7: A word write loads bus bits 23:0 into the middle word, fills the extension with copies of bit 23 and clears the low word. A long write loads 48 bits into middle:low and fills the extension with bit 47.
- R8: A paired write loads bus bits 47:24 into the first-named accumulator and bits 23:0 into the other, each with the word-write sign extension and low clearing. Both write enables are high.
- R9: Part writes (codes 4 to 11) replace only the addressed bits and keep the rest from acc_a_i or acc_b_i. The mid:low form keeps the extension byte.
- R10: lim_flag_o is low after reset. It is set on the clock after a read with lim_o high, cleared on the clock after lim_clr_i, and a set in the same cycle as a clear wins.
- R11: With rd_en_i low, bus_o is zero, lim_o is low and the flag does not change. With wr_en_i low, both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_a_i | input | 56 | Current contents of accumulator A |
| acc_b_i | input | 56 | Current contents of accumulator B |
| rd_en_i | input | 1 | Read transfer valid |
| rd_sel_i | input | 4 | Read select code |
| scale_i | input | 2 | Scaling mode |
| lim_clr_i | input | 1 | Clear sticky limit flag |
| wr_en_i | input | 1 | Write transfer valid |
| wr_sel_i | input | 4 | Write select code |
| bus_i | input | 48 | Bus data to be written |
| bus_o | output | 48 | Bus data read |
| lim_o | output | 1 | Current read was saturated |
| lim_flag_o | output | 1 | Sticky limit flag |
| acc_a_wr_o | output | 56 | New value for accumulator A |
| acc_a_we_o | output | 1 | Write enable for accumulator A |
| acc_b_wr_o | output | 56 | New value for accumulator B |
| acc_b_we_o | output | 1 | Write enable for accumulator B |

## Verification
The hardest cases are overflows that scaling creates or removes. A left shift can push an in-range value past the limit. A right shift can pull an out-of-range value back in. A negative value can overflow only after shifting. The stimulus table uses accumulator values chosen so that exactly bit 47 and the extension byte disagree after the shift, in both directions. It also includes a pair read where only one half saturates. The sticky flag is then driven through set, hold, clear and a clear that coincides with a new saturation.

// File: rtl/acc_move_pkg.sv
package acc_move_pkg;
  typedef enum logic [3:0] {
    SEL_WORD_A = 4'd0,
    SEL_WORD_B = 4'd1,
    SEL_PAIR_AB = 4'd2,
    SEL_PAIR_BA = 4'd3,
    SEL_ML_A = 4'd4,
    SEL_ML_B = 4'd5,
    SEL_EXT_A = 4'd6,
    SEL_MID_A = 4'd7,
    SEL_LOW_A = 4'd8,
    SEL_EXT_B = 4'd9,
    SEL_MID_B = 4'd10,
    SEL_LOW_B = 4'd11,
    SEL_LONG_A = 4'd12,
    SEL_LONG_B = 4'd13
  } sel_e;

  typedef enum logic [1:0] {
    SCL_NONE = 2'd0,
    SCL_UP = 2'd1,
    SCL_DOWN = 2'd2,
    SCL_RSVD = 2'd3
  } scale_e;
endpackage

// File: rtl/acc_scale_sat.sv
module acc_scale_sat
  import acc_move_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int WORD_W = 24
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_i,
  input  logic [1:0]                scale_i,
  output logic [WORD_W-1:0]         word_o,
  output logic [2*WORD_W-1:0]       long_o,
  output logic                      ovf_o
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;
  localparam int LNG_W = 2 * WORD_W;
  localparam int CHK_W = EXT_W + 2;

  logic [ACC_W:0] v;
  logic [CHK_W-1:0] top;
  logic sign;

  // v keeps the accumulator alignment, with one extra sign bit on top
  always_comb begin
    case (scale_e'(scale_i))
      SCL_UP:   v = {acc_i, 1'b0};
      SCL_DOWN: v = {acc_i[ACC_W-1], acc_i[ACC_W-1], acc_i[ACC_W-1:1]};
      default:  v = {acc_i[ACC_W-1], acc_i};
    endcase
  end

  assign top  = v[ACC_W:LNG_W-1];
  assign sign = v[ACC_W];
  assign ovf_o = !((&top) || !(|top));

  always_comb begin
    if (ovf_o) begin
      word_o = {sign, {(WORD_W-1){~sign}}};
      long_o = {sign, {(LNG_W-1){~sign}}};
    end else begin
      word_o = v[LNG_W-1:WORD_W];
      long_o = v[LNG_W-1:0];
    end
  end
endmodule

// File: rtl/acc_read_mux.sv
module acc_read_mux
  import acc_move_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int WORD_W = 24
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_a_i,
  input  logic [EXT_W+2*WORD_W-1:0] acc_b_i,
  input  logic [WORD_W-1:0]         word_a_i,
  input  logic [WORD_W-1:0]         word_b_i,
  input  logic [2*WORD_W-1:0]       long_a_i,
  input  logic [2*WORD_W-1:0]       long_b_i,
  input  logic                      ovf_a_i,
  input  logic                      ovf_b_i,
  input  logic                      en_i,
  input  logic [3:0]                sel_i,
  output logic [2*WORD_W-1:0]       bus_o,
  output logic                      lim_o
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;
  localparam int LNG_W = 2 * WORD_W;
  localparam int PAD_W = WORD_W - EXT_W;

  function automatic logic [LNG_W-1:0] zx(input logic [WORD_W-1:0] w);
    return {{WORD_W{1'b0}}, w};
  endfunction

  function automatic logic [LNG_W-1:0] ext_rd(input logic [ACC_W-1:0] a);
    return zx({{PAD_W{a[ACC_W-1]}}, a[ACC_W-1 -: EXT_W]});
  endfunction

  always_comb begin
    bus_o = '0;
    lim_o = 1'b0;
    if (en_i) begin
      case (sel_e'(sel_i))
        SEL_WORD_A:  begin bus_o = zx(word_a_i); lim_o = ovf_a_i; end
        SEL_WORD_B:  begin bus_o = zx(word_b_i); lim_o = ovf_b_i; end
        SEL_LONG_A:  begin bus_o = long_a_i; lim_o = ovf_a_i; end
        SEL_LONG_B:  begin bus_o = long_b_i; lim_o = ovf_b_i; end
        SEL_PAIR_AB: begin bus_o = {word_a_i, word_b_i}; lim_o = ovf_a_i | ovf_b_i; end
        SEL_PAIR_BA: begin bus_o = {word_b_i, word_a_i}; lim_o = ovf_a_i | ovf_b_i; end
        SEL_ML_A:    bus_o = acc_a_i[LNG_W-1:0];
        SEL_ML_B:    bus_o = acc_b_i[LNG_W-1:0];
        SEL_EXT_A:   bus_o = ext_rd(acc_a_i);
        SEL_EXT_B:   bus_o = ext_rd(acc_b_i);
        SEL_MID_A:   bus_o = zx(acc_a_i[LNG_W-1:WORD_W]);
        SEL_MID_B:   bus_o = zx(acc_b_i[LNG_W-1:WORD_W]);
        SEL_LOW_A:   bus_o = zx(acc_a_i[WORD_W-1:0]);
        SEL_LOW_B:   bus_o = zx(acc_b_i[WORD_W-1:0]);
        default:     bus_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/acc_write_fmt.sv
module acc_write_fmt
  import acc_move_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int WORD_W = 24
) (
  input  logic [EXT_W+2*WORD_W-1:0] acc_a_i,
  input  logic [EXT_W+2*WORD_W-1:0] acc_b_i,
  input  logic                      en_i,
  input  logic [3:0]                sel_i,
  input  logic [2*WORD_W-1:0]       bus_i,
  output logic [EXT_W+2*WORD_W-1:0] a_o,
  output logic                      a_we_o,
  output logic [EXT_W+2*WORD_W-1:0] b_o,
  output logic                      b_we_o
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;
  localparam int LNG_W = 2 * WORD_W;

  logic [WORD_W-1:0] hi, lo;
  assign hi = bus_i[LNG_W-1:WORD_W];
  assign lo = bus_i[WORD_W-1:0];

  function automatic logic [ACC_W-1:0] fill_word(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
  endfunction

  function automatic logic [ACC_W-1:0] fill_long(input logic [LNG_W-1:0] w);
    return {{EXT_W{w[LNG_W-1]}}, w};
  endfunction

  always_comb begin
    a_o = acc_a_i;
    b_o = acc_b_i;
    a_we_o = 1'b0;
    b_we_o = 1'b0;
    if (en_i) begin
      case (sel_e'(sel_i))
        SEL_WORD_A:  begin a_o = fill_word(lo); a_we_o = 1'b1; end
        SEL_WORD_B:  begin b_o = fill_word(lo); b_we_o = 1'b1; end
        SEL_LONG_A:  begin a_o = fill_long(bus_i); a_we_o = 1'b1; end
        SEL_LONG_B:  begin b_o = fill_long(bus_i); b_we_o = 1'b1; end
        SEL_PAIR_AB: begin
          a_o = fill_word(hi); b_o = fill_word(lo);
          a_we_o = 1'b1; b_we_o = 1'b1;
        end
        SEL_PAIR_BA: begin
          b_o = fill_word(hi); a_o = fill_word(lo);
          a_we_o = 1'b1; b_we_o = 1'b1;
        end
        SEL_ML_A:  begin a_o = {acc_a_i[ACC_W-1:LNG_W], bus_i}; a_we_o = 1'b1; end
        SEL_ML_B:  begin b_o = {acc_b_i[ACC_W-1:LNG_W], bus_i}; b_we_o = 1'b1; end
        SEL_EXT_A: begin a_o = {lo[EXT_W-1:0], acc_a_i[LNG_W-1:0]}; a_we_o = 1'b1; end
        SEL_EXT_B: begin b_o = {lo[EXT_W-1:0], acc_b_i[LNG_W-1:0]}; b_we_o = 1'b1; end
        SEL_MID_A: begin
          a_o = {acc_a_i[ACC_W-1:LNG_W], lo, acc_a_i[WORD_W-1:0]}; a_we_o = 1'b1;
        end
        SEL_MID_B: begin
          b_o = {acc_b_i[ACC_W-1:LNG_W], lo, acc_b_i[WORD_W-1:0]}; b_we_o = 1'b1;
        end
        SEL_LOW_A: begin a_o = {acc_a_i[ACC_W-1:WORD_W], lo}; a_we_o = 1'b1; end
        SEL_LOW_B: begin b_o = {acc_b_i[ACC_W-1:WORD_W], lo}; b_we_o = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_move_shift_limit.sv
module acc_move_shift_limit
  import acc_move_pkg::*;
#(
  parameter int EXT_W = 8,
  parameter int WORD_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [EXT_W+2*WORD_W-1:0] acc_a_i,
  input  logic [EXT_W+2*WORD_W-1:0] acc_b_i,
  input  logic                      rd_en_i,
  input  logic [3:0]                rd_sel_i,
  input  logic [1:0]                scale_i,
  input  logic                      lim_clr_i,
  input  logic                      wr_en_i,
  input  logic [3:0]                wr_sel_i,
  input  logic [2*WORD_W-1:0]       bus_i,
  output logic [2*WORD_W-1:0]       bus_o,
  output logic                      lim_o,
  output logic                      lim_flag_o,
  output logic [EXT_W+2*WORD_W-1:0] acc_a_wr_o,
  output logic                      acc_a_we_o,
  output logic [EXT_W+2*WORD_W-1:0] acc_b_wr_o,
  output logic                      acc_b_we_o
);
  localparam int ACC_W = EXT_W + 2 * WORD_W;
  localparam int LNG_W = 2 * WORD_W;
  localparam int N_ACC = 2;

  logic [ACC_W-1:0]  acc_v  [N_ACC];
  logic [WORD_W-1:0] word_v [N_ACC];
  logic [LNG_W-1:0]  long_v [N_ACC];
  logic              ovf_v  [N_ACC];

  assign acc_v[0] = acc_a_i;
  assign acc_v[1] = acc_b_i;

  for (genvar g = 0; g < N_ACC; g++) begin : g_scl
    acc_scale_sat #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_scl (
      .acc_i  (acc_v[g]),
      .scale_i(scale_i),
      .word_o (word_v[g]),
      .long_o (long_v[g]),
      .ovf_o  (ovf_v[g])
    );
  end

  acc_read_mux #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_rd (
    .acc_a_i (acc_a_i),
    .acc_b_i (acc_b_i),
    .word_a_i(word_v[0]),
    .word_b_i(word_v[1]),
    .long_a_i(long_v[0]),
    .long_b_i(long_v[1]),
    .ovf_a_i (ovf_v[0]),
    .ovf_b_i (ovf_v[1]),
    .en_i    (rd_en_i),
    .sel_i   (rd_sel_i),
    .bus_o   (bus_o),
    .lim_o   (lim_o)
  );

  acc_write_fmt #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_wr (
    .acc_a_i(acc_a_i),
    .acc_b_i(acc_b_i),
    .en_i   (wr_en_i),
    .sel_i  (wr_sel_i),
    .bus_i  (bus_i),
    .a_o    (acc_a_wr_o),
    .a_we_o (acc_a_we_o),
    .b_o    (acc_b_wr_o),
    .b_we_o (acc_b_we_o)
  );

  // sticky limit flag; a new saturation outranks a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lim_flag_o <= 1'b0;
    else if (rd_en_i && lim_o)  lim_flag_o <= 1'b1;
    else if (lim_clr_i)         lim_flag_o <= 1'b0;
  end

  assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && lim_o) |=> lim_flag_o);
  assert_flag_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_clr_i && !(rd_en_i && lim_o)) |=> !lim_flag_o);
  assert_idle_rd_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (bus_o == '0 && !lim_o));
  assert_idle_wr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (!acc_a_we_o && !acc_b_we_o));
  assert_raw_nolim_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i >= 4'd4 && rd_sel_i <= 4'd11) |-> !lim_o);
  assert_sat_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i == 4'd0 && lim_o) |->
      (bus_o[WORD_W-1:0] == {1'b0, {(WORD_W-1){1'b1}}} ||
       bus_o[WORD_W-1:0] == {1'b1, {(WORD_W-1){1'b0}}}));
  assert_word_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 4'd0) |->
      (acc_a_wr_o[WORD_W-1:0] == '0 &&
       ($countones(acc_a_wr_o[ACC_W-1:LNG_W-1]) == 0 ||
        $countones(acc_a_wr_o[ACC_W-1:LNG_W-1]) == EXT_W + 1)));
endmodule

// File: tb/acc_move_shift_limit_tb_top.sv
module acc_move_shift_limit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [55:0] acc_a = '0, acc_b = '0;
  logic rd_en = 1'b0, lim_clr = 1'b0, wr_en = 1'b0;
  logic [3:0] rd_sel = '0, wr_sel = '0;
  logic [1:0] scale = '0;
  logic [47:0] bus_in = '0;
  logic [47:0] bus_out;
  logic lim, lim_flag, a_we, b_we;
  logic [55:0] a_wr, b_wr;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  acc_move_shift_limit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_a_i(acc_a), .acc_b_i(acc_b),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .scale_i(scale), .lim_clr_i(lim_clr),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .bus_i(bus_in),
    .bus_o(bus_out), .lim_o(lim), .lim_flag_o(lim_flag),
    .acc_a_wr_o(a_wr), .acc_a_we_o(a_we), .acc_b_wr_o(b_wr), .acc_b_we_o(b_we)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  localparam logic [55:0] P1 = 56'h00_123456_789ABC;
  localparam logic [55:0] N1 = 56'hFF_876543_210FED;
  localparam logic [55:0] OVP = 56'h01_000000_000000;
  localparam logic [55:0] OVN = 56'hFE_000000_000000;
  localparam int NV = 21;
  // {acc_a, acc_b, sel, scale, expected bus, expected lim}
  localparam logic [166:0] VEC [NV] = '{
    {P1, 56'h0, 4'd0, 2'd0, 48'h000000123456, 1'b0},            // R2
    {P1, 56'h0, 4'd12, 2'd0, 48'h123456789ABC, 1'b0},           // R3
    {OVP, 56'h0, 4'd0, 2'd0, 48'h0000007FFFFF, 1'b1},           // R2
    {OVN, 56'h0, 4'd12, 2'd0, 48'h800000000000, 1'b1},          // R3
    {56'h0, N1, 4'd1, 2'd0, 48'h000000876543, 1'b0},            // R2
    {P1, 56'h0, 4'd0, 2'd1, 48'h0000002468AC, 1'b0},            // R4
    {56'h00_400000_000000, 56'h0, 4'd0, 2'd1, 48'h0000007FFFFF, 1'b1}, // R4
    {56'h00_F00000_000000, 56'h0, 4'd0, 2'd2, 48'h000000780000, 1'b0}, // R4
    {P1, N1, 4'd2, 2'd0, 48'h123456876543, 1'b0},               // R5
    {OVP, N1, 4'd3, 2'd0, 48'h8765437FFFFF, 1'b1},              // R5
    {56'h01_ABCDEF_123456, 56'h0, 4'd4, 2'd0, 48'hABCDEF123456, 1'b0}, // R6
    {56'h9C_000000_000000, 56'h0, 4'd6, 2'd0, 48'h000000FFFF9C, 1'b0}, // R6
    {P1, 56'h0, 4'd8, 2'd0, 48'h000000789ABC, 1'b0},            // R6
    {56'h0, OVN, 4'd10, 2'd0, 48'h000000000000, 1'b0},          // R6
    {56'h0, N1, 4'd11, 2'd0, 48'h000000210FED, 1'b0},           // R6
    {P1, 56'h0, 4'd12, 2'd1, 48'h2468ACF13578, 1'b0},           // R4
    {56'h0, N1, 4'd13, 2'd2, 48'hC3B2A19087F6, 1'b0},           // R4
    {P1, N1, 4'd15, 2'd0, 48'h000000000000, 1'b0},              // R1
    {OVP, 56'h0, 4'd0, 2'd3, 48'h0000007FFFFF, 1'b1},           // R4
    {OVN, 56'h0, 4'd0, 2'd0, 48'h000000800000, 1'b1},           // R2
    {56'h0, N1, 4'd1, 2'd1, 48'h000000800000, 1'b1}             // R4
  };

  task automatic rd(input logic [55:0] a, input logic [55:0] b, input logic [3:0] s,
                    input logic [1:0] sc, input logic en);
    @(negedge clk);
    acc_a = a; acc_b = b; rd_sel = s; scale = sc; rd_en = en;
  endtask

  task automatic wr(input logic [3:0] s, input logic [47:0] d);
    @(negedge clk);
    wr_sel = s; bus_in = d; wr_en = 1'b1;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset flag", 64'(lim_flag), 64'd0);
    chk("R11 reset bus", 64'(bus_out), 64'd0);
    rst_n = 1'b1;

    // R11: saturating source but no read enable
    rd(OVP, 56'h0, 4'd0, 2'd0, 1'b0);
    #1;
    chk("R11 idle bus", 64'(bus_out), 64'd0);
    chk("R11 idle lim", 64'(lim), 64'd0);
    @(posedge clk); #1;
    chk("R11 idle flag", 64'(lim_flag), 64'd0);

    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][166:111], VEC[i][110:55], VEC[i][54:51], VEC[i][50:49], 1'b1);
      #1;
      chk($sformatf("R1-table row %0d bus", i), 64'(bus_out), 64'(VEC[i][48:1]));
      chk($sformatf("R2 table row %0d lim", i), 64'(lim), 64'(VEC[i][0]));
    end

    // R10 sticky flag sequence
    @(negedge clk); rd_en = 1'b0; lim_clr = 1'b1;
    @(posedge clk); #1;
    chk("R10 clear", 64'(lim_flag), 64'd0);
    @(negedge clk); lim_clr = 1'b0;
    rd(P1, 56'h0, 4'd0, 2'd0, 1'b1);
    @(posedge clk); #1;
    chk("R10 no set in range", 64'(lim_flag), 64'd0);
    rd(OVP, 56'h0, 4'd0, 2'd0, 1'b1);
    @(posedge clk); #1;
    chk("R10 set", 64'(lim_flag), 64'd1);
    rd(P1, 56'h0, 4'd0, 2'd0, 1'b1);
    @(posedge clk); #1;
    chk("R10 hold", 64'(lim_flag), 64'd1);
    @(negedge clk); lim_clr = 1'b1;
    @(posedge clk); #1;
    chk("R10 clear again", 64'(lim_flag), 64'd0);
    rd(OVN, 56'h0, 4'd0, 2'd0, 1'b1);
    @(posedge clk); #1;
    chk("R10 set beats clear", 64'(lim_flag), 64'd1);
    @(negedge clk); lim_clr = 1'b0; rd_en = 1'b0;

    // writes
    acc_a = P1; acc_b = N1;
    wr(4'd0, 48'h000000_812345);
    chk("R7 word A", 64'(a_wr), 64'(56'hFF_812345_000000));
    chk("R7 word A we", 64'({a_we, b_we}), 64'd2);
    wr(4'd12, 48'h123456_ABCDEF);
    chk("R7 long A", 64'(a_wr), 64'(56'h00_123456_ABCDEF));
    wr(4'd13, 48'h800000_000001);
    chk("R7 long B", 64'(b_wr), 64'(56'hFF_800000_000001));
    wr(4'd2, 48'h7ABCDE_876543);
    chk("R8 pair AB a", 64'(a_wr), 64'(56'h00_7ABCDE_000000));
    chk("R8 pair AB b", 64'(b_wr), 64'(56'hFF_876543_000000));
    chk("R8 pair we", 64'({a_we, b_we}), 64'd3);
    wr(4'd3, 48'h111111_922222);
    chk("R8 pair BA b", 64'(b_wr), 64'(56'h00_111111_000000));
    chk("R8 pair BA a", 64'(a_wr), 64'(56'hFF_922222_000000));
    acc_a = 56'h5A_000000_000000;
    wr(4'd4, 48'h800000_000001);
    chk("R9 mid:low keeps ext", 64'(a_wr), 64'(56'h5A_800000_000001));
    acc_a = P1;
    wr(4'd6, 48'h000000_0000C3);
    chk("R9 ext A", 64'(a_wr), 64'(56'hC3_123456_789ABC));
    wr(4'd8, 48'h000000_C0FFEE);
    chk("R9 low A", 64'(a_wr), 64'(56'h00_123456_C0FFEE));
    wr(4'd10, 48'h000000_ABCDEF);
    chk("R9 mid B", 64'(b_wr), 64'(56'hFF_ABCDEF_210FED));
    chk("R9 mid B we", 64'({a_we, b_we}), 64'd1);
    wr(4'd15, 48'hFFFFFF_FFFFFF);
    chk("R1 unused write code", 64'({a_we, b_we}), 64'd0);
    @(negedge clk); wr_en = 1'b0; wr_sel = 4'd0; #1;
    chk("R11 write idle", 64'({a_we, b_we}), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule